// File: doc/BRIEF.md
# Two-Cycle Pipelined Control-Word Fetch

This block feeds a wide control word to a datapath every clock cycle from an on-chip instruction store. The store's read is split across two clock edges. The first edge captures the address and decodes the row. The second edge fires the sense stage and registers the word. Because of this split, the fetch unit issues the address of the word needed in cycle n+1 during cycle n. A program counter advances by one per issued word, so sequential code runs at one word per cycle with no stalls.

When the consumer requests a jump, the block discards the sequential address already in the decode stage and issues the jump target in its place. The discarded slot reaches the output as a single bubble: the valid flag is low and the word is all zeros, so it acts as a NOP. The target word follows on the next cycle.

A load port writes words into the store before or between runs. Every delivered word carries its store address alongside the valid flag.

Top module: `cw_fetch_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cw_vld` is 0 and `cw_out` is all zeros. The program counter restarts at address 0.
- R2: The first edge with `fetch_en` high issues an address. The word at that address appears with `cw_vld` high after the second edge counted from that issue edge.
- R3: While `fetch_en` stays high and no jump occurs, the block delivers one word per cycle with no gaps, and each `cw_addr` is the previous one plus 1.
- R4: Sequential fetch wraps from address DEPTH-1 to address 0.
- R5: An edge with `jump_vld` and `fetch_en` both high has two effects. The cycle after it is a bubble, with `cw_vld` at 0 and `cw_out` all zeros. The cycle after that delivers the word at `jump_tgt`, followed by sequential words from there.
- R6: When jumps arrive on two consecutive edges, the first target is never delivered. Two bubble cycles appear, then the second target's word.
- R7: An edge with `fetch_en` low issues nothing. The word already in flight is still delivered after the next edge, and the output then stays invalid. When fetch resumes, it continues from the next sequential address.
- R8: A load with `ld_en` high writes `ld_data` at `ld_addr` on that edge. Any read whose sense edge comes later returns the new word. This includes a jump to that same address on the same edge.
- R9: A jump on an edge with `fetch_en` low issues nothing. It redirects the program counter, so the first word delivered after fetch resumes is the target word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en | input | 1 | Issue an address on this edge |
| jump_vld | input | 1 | Redirect fetch to `jump_tgt` |
| jump_tgt | input | AW | Jump target address |
| ld_en | input | 1 | Write `ld_data` into the store |
| ld_addr | input | AW | Store write address |
| ld_data | input | WORD_W | Store write data |
| cw_vld | output | 1 | Delivered word is valid |
| cw_addr | output | AW | Store address of delivered word |
| cw_out | output | WORD_W | Delivered control word, zero when invalid |

## Verification
Two functions can act on one edge: a jump into an address and a load into that same address. The bench provokes this by raising `jump_vld` and `ld_en` together with matching addresses. It then requires one bubble, followed by the freshly loaded word rather than the stale one. Back-to-back jumps and a jump while fetch is paused are also driven. In each case the bench judges by the exact cycle and count of bubbles in the `cw_vld`/`cw_addr` stream.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  // Source of the address latched into the decode stage on an edge.
  typedef enum logic [1:0] {
    ISS_NONE = 2'd0,
    ISS_SEQ  = 2'd1,
    ISS_JUMP = 2'd2
  } iss_src_e;

  // Next sequential address, wrapping at the store depth.
  function automatic logic [31:0] wrap_inc(input logic [31:0] a, input int unsigned depth);
    logic [31:0] n;
    n = a + 32'd1;
    return (n >= depth) ? 32'd0 : n;
  endfunction

endpackage

// File: rtl/cwf_issue.sv
module cwf_issue #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_en,
  input  logic          jump_vld,
  input  logic [AW-1:0] jump_tgt,
  output logic          iss_vld,
  output logic [AW-1:0] iss_addr,
  output logic          iss_kill
);
  import cwf_pkg::*;

  logic [AW-1:0] pc_q, pc_d;
  iss_src_e      src;

  always_comb begin
    src = ISS_NONE;
    if (jump_vld && fetch_en) src = ISS_JUMP;
    else if (!jump_vld && fetch_en) src = ISS_SEQ;
  end

  assign iss_vld  = (src != ISS_NONE);
  assign iss_addr = (src == ISS_JUMP) ? jump_tgt : pc_q;
  // A jump discards whatever sits in the decode stage.
  assign iss_kill = jump_vld;

  always_comb begin
    pc_d = pc_q;
    case (src)
      ISS_JUMP: pc_d = AW'(wrap_inc(32'(jump_tgt), DEPTH));
      ISS_SEQ:  pc_d = AW'(wrap_inc(32'(pc_q), DEPTH));
      default:  pc_d = jump_vld ? jump_tgt : pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R9: a jump with fetch paused parks the counter on the target.
  assert_pc_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_vld && !fetch_en) |=> (pc_q == $past(jump_tgt)));

  // R3: a sequential issue moves the counter on by exactly one.
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !jump_vld) |=> (pc_q == AW'(wrap_inc(32'($past(iss_addr)), DEPTH))));

endmodule

// File: rtl/cwf_imem.sv
module cwf_imem #(
  parameter int WORD_W = 160,
  parameter int DEPTH  = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              iss_vld,
  input  logic [AW-1:0]     iss_addr,
  input  logic              iss_kill,
  output logic              sense_vld,
  output logic [AW-1:0]     sense_addr,
  output logic [WORD_W-1:0] sense_word
);

  logic [WORD_W-1:0] store [DEPTH];
  logic              row_vld_q;
  logic [AW-1:0]     row_addr_q;
  logic              fire_sense;

  always_ff @(posedge clk) begin
    if (ld_en) store[ld_addr] <= ld_data;
  end

  // Stage one: latch address, row decode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_vld_q  <= 1'b0;
      row_addr_q <= '0;
    end else begin
      row_vld_q  <= iss_vld;
      row_addr_q <= iss_addr;
    end
  end

  assign fire_sense = row_vld_q && !iss_kill;

  // Stage two: sense enable, register word; bubbles carry zeros.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_vld  <= 1'b0;
      sense_addr <= '0;
      sense_word <= '0;
    end else if (fire_sense) begin
      sense_vld  <= 1'b1;
      sense_addr <= row_addr_q;
      sense_word <= store[row_addr_q];
    end else begin
      sense_vld  <= 1'b0;
      sense_addr <= '0;
      sense_word <= '0;
    end
  end

  // R2: an issued address reaches the sense stage one edge later unless killed.
  assert_issue_to_sense_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && !iss_kill) ##1 !iss_kill |=> (sense_vld && sense_addr == $past(iss_addr, 2)));

  // R5: an invalid sense slot never carries a nonzero word.
  assert_bubble_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_vld |-> (sense_word == '0));

endmodule

// File: rtl/cw_fetch_unit.sv
module cw_fetch_unit #(
  parameter int WORD_W = 160,
  parameter int DEPTH  = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic              jump_vld,
  input  logic [AW-1:0]     jump_tgt,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic              cw_vld,
  output logic [AW-1:0]     cw_addr,
  output logic [WORD_W-1:0] cw_out
);

  logic          iss_vld;
  logic [AW-1:0] iss_addr;
  logic          iss_kill;

  cwf_issue #(.DEPTH(DEPTH)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_en (fetch_en),
    .jump_vld (jump_vld),
    .jump_tgt (jump_tgt),
    .iss_vld  (iss_vld),
    .iss_addr (iss_addr),
    .iss_kill (iss_kill)
  );

  cwf_imem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_imem (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .iss_vld    (iss_vld),
    .iss_addr   (iss_addr),
    .iss_kill   (iss_kill),
    .sense_vld  (cw_vld),
    .sense_addr (cw_addr),
    .sense_word (cw_out)
  );

  // Port history kept for the checks below.
  logic          en_q1, en_q2, jv_q1, jtake_q1, jtake_q2;
  logic [AW-1:0] tgt_q1, tgt_q2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q1 <= 1'b0; en_q2 <= 1'b0; jv_q1 <= 1'b0;
      jtake_q1 <= 1'b0; jtake_q2 <= 1'b0;
      tgt_q1 <= '0; tgt_q2 <= '0;
    end else begin
      en_q1    <= fetch_en;
      en_q2    <= en_q1;
      jv_q1    <= jump_vld;
      jtake_q1 <= jump_vld && fetch_en;
      jtake_q2 <= jtake_q1;
      tgt_q1   <= jump_tgt;
      tgt_q2   <= tgt_q1;
    end
  end

  // R5: one bubble right after a jump edge.
  assert_jump_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    jump_vld |=> !cw_vld);

  // R5/R6: target delivered two edges after its jump unless a newer jump squashed it.
  assert_target_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (jtake_q2 && !jv_q1) |-> (cw_vld && cw_addr == tgt_q2));

  // R3/R4: back-to-back valid words are consecutive addresses, wrapping.
  assert_seq_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_vld && $past(cw_vld)) |-> (cw_addr == AW'(cwf_pkg::wrap_inc(32'($past(cw_addr)), DEPTH))));

  // R7: no issue two edges back means nothing delivered now.
  assert_idle_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q2 |-> !cw_vld);

  // R1: one cycle after reset ends the output is still quiet.
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!cw_vld && cw_out == '0));

endmodule

// File: tb/cw_fetch_unit_tb.sv
module cw_fetch_unit_tb;
  localparam int W = 160;
  localparam int D = 256;
  localparam int A = 8;
  localparam int NV = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_en = 1'b0, jump_vld = 1'b0, ld_en = 1'b0;
  logic [A-1:0]  jump_tgt = '0, ld_addr = '0;
  logic [W-1:0]  ld_data = '0;
  logic          cw_vld;
  logic [A-1:0]  cw_addr;
  logic [W-1:0]  cw_out;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] shadow [D];

  always #10 clk = ~clk;  // 50 MHz

  cw_fetch_unit #(.WORD_W(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .jump_vld(jump_vld),
    .jump_tgt(jump_tgt), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .cw_vld(cw_vld), .cw_addr(cw_addr), .cw_out(cw_out)
  );

  function automatic logic [W-1:0] pat(input int i);
    logic [31:0] s;
    s = (32'h9E3779B9 * 32'(i + 1)) ^ 32'h0F0F0000;
    return {5{s}};
  endfunction

  // Row: {fetch_en, jump_vld, jump_tgt, exp_vld, exp_addr} ; expectation is after that edge.
  localparam logic [18:0] VEC [NV] = '{
    {1'b1,1'b0,8'h00, 1'b0,8'h00},  // 0  R2 first edge: nothing yet
    {1'b1,1'b0,8'h00, 1'b1,8'h00},  // 1  R2 word 0
    {1'b1,1'b0,8'h00, 1'b1,8'h01},  // 2  R3
    {1'b1,1'b0,8'h00, 1'b1,8'h02},  // 3  R3
    {1'b1,1'b1,8'h40, 1'b0,8'h00},  // 4  R5 bubble
    {1'b1,1'b0,8'h00, 1'b1,8'h40},  // 5  R5 target
    {1'b1,1'b0,8'h00, 1'b1,8'h41},  // 6  R5 continues
    {1'b1,1'b1,8'h10, 1'b0,8'h00},  // 7  R6 first jump
    {1'b1,1'b1,8'h20, 1'b0,8'h00},  // 8  R6 second jump
    {1'b1,1'b0,8'h00, 1'b1,8'h20},  // 9  R6 only second target
    {1'b0,1'b0,8'h00, 1'b1,8'h21},  // 10 R7 in-flight word drains
    {1'b0,1'b0,8'h00, 1'b0,8'h00},  // 11 R7 idle
    {1'b0,1'b1,8'hFE, 1'b0,8'h00},  // 12 R9 jump while paused
    {1'b1,1'b0,8'h00, 1'b0,8'h00},  // 13 R9 resume issue
    {1'b1,1'b0,8'h00, 1'b1,8'hFE},  // 14 R9 target first
    {1'b1,1'b0,8'h00, 1'b1,8'hFF},  // 15 R4
    {1'b1,1'b0,8'h00, 1'b1,8'h00},  // 16 R4 wrap
    {1'b1,1'b0,8'h00, 1'b1,8'h01},  // 17 R4
    {1'b0,1'b0,8'h00, 1'b1,8'h02},  // 18 R7 drain
    {1'b0,1'b0,8'h00, 1'b0,8'h00},  // 19 R7 idle
    {1'b1,1'b0,8'h00, 1'b0,8'h00},  // 20 R7 resume
    {1'b1,1'b0,8'h00, 1'b1,8'h03},  // 21 R7 continues sequentially
    {1'b1,1'b0,8'h00, 1'b1,8'h04}   // 22 R3
  };

  task automatic chk(input string req, input logic ev, input logic [A-1:0] ea);
    logic [W-1:0] ed;
    ed = ev ? shadow[ea] : '0;
    n_chk++;
    if (cw_vld !== ev || (ev && cw_addr !== ea) || cw_out !== ed) begin
      n_bad++;
      $display("FAIL %s: vld=%0b addr=%h data=%h expected vld=%0b addr=%h data=%h",
               req, cw_vld, cw_addr, cw_out, ev, ea, ed);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (ld_en) shadow[ld_addr] = ld_data;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, '0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", 1'b0, '0);
    // Load the whole store with fetch paused.
    for (int i = 0; i < D; i++) begin
      ld_en = 1'b1; ld_addr = A'(i); ld_data = pat(i);
      tick();
    end
    ld_en = 1'b0;
    chk("R1 counter idle during load", 1'b0, '0);

    for (int v = 0; v < NV; v++) begin
      fetch_en = VEC[v][18]; jump_vld = VEC[v][17]; jump_tgt = VEC[v][16:9];
      tick();
      chk($sformatf("R3/R4/R5/R6/R7/R9 vector %0d", v), VEC[v][8], VEC[v][7:0]);
    end

    // R8: jump and load to the same address on one edge.
    fetch_en = 1'b1; jump_vld = 1'b1; jump_tgt = 8'h30;
    ld_en = 1'b1; ld_addr = 8'h30; ld_data = ~pat(7);
    tick();
    chk("R8 bubble at coincident jump+load", 1'b0, '0);
    jump_vld = 1'b0; ld_en = 1'b0;
    tick();
    chk("R8 fresh word at target", 1'b1, 8'h30);
    tick();
    chk("R8 next sequential", 1'b1, 8'h31);
    fetch_en = 1'b0;
    tick(); tick();
    chk("R7 idle after stop", 1'b0, '0);

    // R1/R2: reset mid-run restarts at 0.
    fetch_en = 1'b1;
    tick();
    rst_n = 1'b0;
    tick();
    chk("R1 reset clears output", 1'b0, '0);
    rst_n = 1'b1;
    tick();
    chk("R2 first edge after reset", 1'b0, '0);
    tick();
    chk("R2 word 0 after restart", 1'b1, 8'h00);
    tick();
    chk("R3 word 1 after restart", 1'b1, 8'h01);
    fetch_en = 1'b0;
    tick();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule